// File: doc/BRIEF.md
# Compressed L3 Header Parser

This block sits directly behind the L2 protocol match of a fabric port. It takes the start of an already-classified frame payload as a stream of 32-bit words and unpacks a compact, variable-length L3 header. The header carries traffic class, a 4-bit hop limit, flow label and next-header fields, plus two 4-bit length codes. Those codes set how many source and destination address bytes follow, from 1 to 16 each. Each address is delivered right-aligned and zero-extended to 128 bits.

From the two codes the parser computes the padded header size. It then derives the payload byte count from the frame length, which is given with the first word. It flags the exact input word where the payload begins. When the frame closes before the header is complete, it reports truncation instead of a result.

Words are accepted on every cycle where `in_valid` is high. The first valid word after idle is header word 0, and `in_last` closes the frame. Fields, lengths and addresses are stable from the cycle of `hdr_valid` until the next frame's header words arrive.

Top module: `chp_hdr_parser`

## Requirements
- R1: Word 0 is split with bit 31 as the first header bit: traffic class = word[31:24], hop limit = word[23:20], flow label = word[19:0].
- R2: Word 1 gives next header = word[31:24], source length code = word[23:20], destination length code = word[19:16]; the address bytes start at header byte 6 (word 1 bits [15:8]).
- R3: An address length code of 0 means 16 bytes; any other code c means c bytes.
- R4: `hdr_len` equals (6 + source bytes + destination bytes) rounded up to a multiple of 4, e.g. codes 1/1 give 8, 2/2 give 12, 3/3 give 12, 4/4 give 16, 4/0 give 28, 0/0 give 40.
- R5: `pay_len` equals the frame length sampled with word 0 minus `hdr_len`.
- R6: The source bytes come first and the destination bytes follow at once with no alignment; each address puts its first byte most significant and is zero-extended above its length.
- R7: Padding bytes between the last destination byte and the 4-byte boundary do not change any output.
- R8: `hdr_valid` is a one-cycle pulse in the cycle after the last header word is accepted, and never comes twice in a row.
- R9: `pay_start` is high exactly while the first word after the header is presented with `in_valid`.
- R10: When `in_last` arrives on a word before the last header word, `trunc_err` pulses in the next cycle and no `hdr_valid` is produced for that frame.
- R11: After reset, `hdr_valid`, `trunc_err` and `pay_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_last | input | 1 | Input word is the last of the frame |
| in_data | input | 32 | Input word, first byte in bits [31:24] |
| in_frm_len | input | 16 | Frame length in bytes, sampled with header word 0 |
| hdr_valid | output | 1 | One-cycle pulse: all parsed fields valid |
| trunc_err | output | 1 | One-cycle pulse: frame ended inside the header |
| pay_start | output | 1 | Current input word is the first payload word |
| traffic_class | output | 8 | Traffic class field |
| hop_limit | output | 4 | Hop limit field |
| flow_label | output | 20 | Flow label field |
| next_hdr | output | 8 | Next header field |
| src_code | output | 4 | Source address length code |
| dst_code | output | 4 | Destination address length code |
| src_addr | output | 128 | Source address, zero-extended |
| dst_addr | output | 128 | Destination address, zero-extended |
| hdr_len | output | 6 | Padded header length in bytes |
| pay_len | output | 16 | Payload length in bytes |

## Verification
The checker assumes that `in_last` is only meaningful with `in_valid`. It also assumes that every frame has at least two words whenever its header is complete, so two result pulses can never fall on adjacent cycles. The bench sends each frame as an unbroken run of valid words with at least one idle cycle after it. It raises `in_last` only on the final word and truncates frames only by cutting them short. This keeps the stimulus inside those assumptions and lines up each first payload word with the result pulse.

// File: rtl/chp_pkg.sv
// Shared constants, state encoding and length-code decode for the
// compressed L3 header parser. Assumes 32-bit input words.
package chp_pkg;
    localparam int WORD_W    = 32;
    localparam int CODE_W    = 4;
    localparam int ABYTES_W  = 5;   // holds 1..16
    localparam int FIXED_HDR = 6;   // bytes ahead of the addresses

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY1 = 2'd2,
        ST_PAYN = 2'd3
    } chp_state_e;

    // Address byte count for a 4-bit code: the zero code is the full-size escape.
    function automatic logic [ABYTES_W-1:0] code_bytes(input logic [CODE_W-1:0] c);
        return (c == '0) ? ABYTES_W'(16) : {1'b0, c};
    endfunction
endpackage

// File: rtl/chp_len_calc.sv
// Length arithmetic: turns the two address codes into byte counts, the
// padded header length and the index of the last header word.
// Assumes the header never exceeds 40 bytes (two 16-byte addresses).
module chp_len_calc
    import chp_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int WIDX_W = 4
) (
    input  logic [CODE_W-1:0]   sa_code,
    input  logic [CODE_W-1:0]   da_code,
    output logic [ABYTES_W-1:0] sa_bytes,
    output logic [ABYTES_W-1:0] da_bytes,
    output logic [LEN_W-1:0]    hdr_bytes,
    output logic [WIDX_W-1:0]   last_widx
);
    logic [LEN_W-1:0] raw_sum;
    logic [LEN_W-1:0] rounded;

    // Decode codes, add the fixed part and round up to the next 4-byte boundary.
    always_comb begin
        sa_bytes  = code_bytes(sa_code);
        da_bytes  = code_bytes(da_code);
        raw_sum   = LEN_W'(FIXED_HDR) + LEN_W'(sa_bytes) + LEN_W'(da_bytes);
        rounded   = raw_sum + LEN_W'(3);
        hdr_bytes = {rounded[LEN_W-1:2], 2'b00};
        last_widx = WIDX_W'(hdr_bytes[LEN_W-1:2]) - WIDX_W'(1);
    end
endmodule

// File: rtl/chp_addr_shift.sv
// Byte collector for one address: each of the four byte lanes of the
// current word is shifted into the address register when the lane's
// header byte offset falls inside [start, start+count). Lanes are taken in
// stream order so the first address byte ends up most significant.
module chp_addr_shift
    import chp_pkg::*;
#(
    parameter int ADDR_W = 128,
    parameter int WIDX_W = 4,
    parameter int OFS_W  = 7
) (
    input  logic [WORD_W-1:0]   word,
    input  logic [WIDX_W-1:0]   widx,
    input  logic [OFS_W-1:0]    start,
    input  logic [ABYTES_W-1:0] count,
    input  logic [ADDR_W-1:0]   cur,
    output logic [ADDR_W-1:0]   nxt
);
    localparam int LANES = WORD_W / 8;

    logic [ADDR_W-1:0] chain [0:LANES];
    logic [OFS_W-1:0]  stop;

    // End offset (exclusive) of this address inside the header.
    always_comb stop = start + OFS_W'(count);

    assign chain[0] = cur;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [OFS_W-1:0] ofs;
        logic             take;
        logic [7:0]       byte_v;
        // Offset of this lane in the header and whether it belongs to the address.
        always_comb begin
            ofs    = OFS_W'({widx, 2'b00}) + OFS_W'(j);
            take   = (ofs >= start) && (ofs < stop);
            byte_v = word[WORD_W-1-8*j -: 8];
        end
        assign chain[j+1] = take ? {chain[j][ADDR_W-9:0], byte_v} : chain[j];
    end

    assign nxt = chain[LANES];
endmodule

// File: rtl/chp_frame_fsm.sv
// Frame sequencer: tracks which header word is on the input, detects the
// end of the header, a frame that ends inside the header, and the first
// payload word. The first valid word after idle is header word 0.
module chp_frame_fsm
    import chp_pkg::*;
#(
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [WIDX_W-1:0] last_widx,
    output logic [WIDX_W-1:0] widx,
    output logic              take_w0,
    output logic              take_w1,
    output logic              take_hdr,
    output logic              hdr_end,
    output logic              trunc_now,
    output logic              first_pay
);
    chp_state_e        state_q, state_d;
    logic [WIDX_W-1:0] widx_q, widx_d;

    // Next-state and per-word strobes.
    always_comb begin
        state_d   = state_q;
        widx_d    = widx_q;
        take_w0   = 1'b0;
        take_w1   = 1'b0;
        take_hdr  = 1'b0;
        hdr_end   = 1'b0;
        trunc_now = 1'b0;
        first_pay = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    take_w0 = 1'b1;
                    widx_d  = WIDX_W'(1);
                    if (in_last) trunc_now = 1'b1;
                    else         state_d   = ST_HDR;
                end
                ST_HDR: begin
                    take_hdr = 1'b1;
                    take_w1  = (widx_q == WIDX_W'(1));
                    widx_d   = widx_q + WIDX_W'(1);
                    if (widx_q == last_widx) begin
                        hdr_end = 1'b1;
                        state_d = in_last ? ST_IDLE : ST_PAY1;
                    end else if (in_last) begin
                        trunc_now = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end
                ST_PAY1: begin
                    first_pay = 1'b1;
                    state_d   = in_last ? ST_IDLE : ST_PAYN;
                end
                ST_PAYN: begin
                    if (in_last) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and word index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
        end else begin
            state_q <= state_d;
            widx_q  <= widx_d;
        end
    end

    assign widx = widx_q;
endmodule

// File: rtl/chp_hdr_parser.sv
// Top of the compressed L3 header parser. Captures the fixed fields from
// header words 0 and 1, collects both addresses byte by byte, computes
// the padded header length and payload length, and pulses hdr_valid once
// the last header word has been accepted. Assumes in_last is only
// considered together with in_valid and in_frm_len is valid with word 0.
module chp_hdr_parser
    import chp_pkg::*;
#(
    parameter int ADDR_W = 128,
    parameter int FLEN_W = 16,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [31:0]       in_data,
    input  logic [FLEN_W-1:0] in_frm_len,
    output logic              hdr_valid,
    output logic              trunc_err,
    output logic              pay_start,
    output logic [7:0]        traffic_class,
    output logic [3:0]        hop_limit,
    output logic [19:0]       flow_label,
    output logic [7:0]        next_hdr,
    output logic [3:0]        src_code,
    output logic [3:0]        dst_code,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [LEN_W-1:0]  hdr_len,
    output logic [FLEN_W-1:0] pay_len
);
    localparam int WIDX_W = 4;
    localparam int OFS_W  = WIDX_W + 3;

    logic [WIDX_W-1:0]   widx, last_widx;
    logic                take_w0, take_w1, take_hdr, hdr_end, trunc_now, first_pay;
    logic [CODE_W-1:0]   sa_code_q, da_code_q, sa_code_l, da_code_l;
    logic [ABYTES_W-1:0] sa_bytes, da_bytes;
    logic [LEN_W-1:0]    hlen_l;
    logic [ADDR_W-1:0]   src_q, dst_q, src_n, dst_n;
    logic [FLEN_W-1:0]   frm_len_q, pay_len_q;
    logic [7:0]          tc_q, nh_q;
    logic [3:0]          hl_q;
    logic [19:0]         fl_q;
    logic [LEN_W-1:0]    hlen_q;
    logic                valid_q, trunc_q;

    // Live codes: taken straight from word 1 while it is on the input.
    always_comb begin
        sa_code_l = take_w1 ? in_data[23:20] : sa_code_q;
        da_code_l = take_w1 ? in_data[19:16] : da_code_q;
    end

    chp_len_calc #(.LEN_W(LEN_W), .WIDX_W(WIDX_W)) i_len (
        .sa_code  (sa_code_l),
        .da_code  (da_code_l),
        .sa_bytes (sa_bytes),
        .da_bytes (da_bytes),
        .hdr_bytes(hlen_l),
        .last_widx(last_widx)
    );

    chp_frame_fsm #(.WIDX_W(WIDX_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .last_widx(last_widx),
        .widx     (widx),
        .take_w0  (take_w0),
        .take_w1  (take_w1),
        .take_hdr (take_hdr),
        .hdr_end  (hdr_end),
        .trunc_now(trunc_now),
        .first_pay(first_pay)
    );

    chp_addr_shift #(.ADDR_W(ADDR_W), .WIDX_W(WIDX_W), .OFS_W(OFS_W)) i_src (
        .word (in_data),
        .widx (widx),
        .start(OFS_W'(FIXED_HDR)),
        .count(sa_bytes),
        .cur  (src_q),
        .nxt  (src_n)
    );

    chp_addr_shift #(.ADDR_W(ADDR_W), .WIDX_W(WIDX_W), .OFS_W(OFS_W)) i_dst (
        .word (in_data),
        .widx (widx),
        .start(OFS_W'(FIXED_HDR) + OFS_W'(sa_bytes)),
        .count(da_bytes),
        .cur  (dst_q),
        .nxt  (dst_n)
    );

    // Word 0 fields, frame length, and address clear at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q      <= '0;
            hl_q      <= '0;
            fl_q      <= '0;
            frm_len_q <= '0;
        end else if (take_w0) begin
            tc_q      <= in_data[31:24];
            hl_q      <= in_data[23:20];
            fl_q      <= in_data[19:0];
            frm_len_q <= in_frm_len;
        end
    end

    // Word 1 fields and the header length they imply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nh_q      <= '0;
            sa_code_q <= '0;
            da_code_q <= '0;
            hlen_q    <= '0;
        end else if (take_w1) begin
            nh_q      <= in_data[31:24];
            sa_code_q <= in_data[23:20];
            da_code_q <= in_data[19:16];
            hlen_q    <= hlen_l;
        end
    end

    // Address accumulation over the header words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (take_w0) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (take_hdr) begin
            src_q <= src_n;
            dst_q <= dst_n;
        end
    end

    // Result strobes and payload length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            trunc_q   <= 1'b0;
            pay_len_q <= '0;
        end else begin
            valid_q <= hdr_end;
            trunc_q <= trunc_now;
            if (hdr_end) pay_len_q <= frm_len_q - FLEN_W'(hlen_l);
        end
    end

    assign hdr_valid     = valid_q;
    assign trunc_err     = trunc_q;
    assign pay_start     = first_pay;
    assign traffic_class = tc_q;
    assign hop_limit     = hl_q;
    assign flow_label    = fl_q;
    assign next_hdr      = nh_q;
    assign src_code      = sa_code_q;
    assign dst_code      = da_code_q;
    assign src_addr      = src_q;
    assign dst_addr      = dst_q;
    assign hdr_len       = hlen_q;
    assign pay_len       = pay_len_q;
endmodule

// File: rtl/chp_hdr_parser_chk.sv
// Protocol checker for chp_hdr_parser, attached by bind. Assumes in_last is
// only meaningful with in_valid and frames with a full header have at
// least two words.
module chp_hdr_parser_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_last,
    input logic         hdr_valid,
    input logic         trunc_err,
    input logic         pay_start,
    input logic [3:0]   src_code,
    input logic [3:0]   dst_code,
    input logic [127:0] src_addr,
    input logic [127:0] dst_addr,
    input logic [5:0]   hdr_len
);
    logic [7:0] sa_bits, da_bits;

    // Address widths in bits implied by the reported codes.
    always_comb begin
        sa_bits = (src_code == 4'd0) ? 8'd128 : {1'b0, src_code, 3'b000};
        da_bits = (dst_code == 4'd0) ? 8'd128 : {1'b0, dst_code, 3'b000};
    end

    // R4: reported header length is 4-byte aligned and within 8..40.
    a_r4_len_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_len[1:0] == 2'b00 && hdr_len >= 6'd8 && hdr_len <= 6'd40));

    // R6: both addresses are zero above their coded length.
    a_r6_src_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ((src_addr >> sa_bits) == 128'd0));
    a_r6_dst_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ((dst_addr >> da_bits) == 128'd0));

    // R8: the result is a single pulse following an accepted word.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> !hdr_valid);
    a_r8_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(in_valid));

    // R9: the payload marker only accompanies a presented word.
    a_r9_marker_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        pay_start |-> in_valid);

    // R10: truncation never coincides with a result and follows a closing word.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_valid && trunc_err));
    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_err |-> $past(in_valid && in_last));
endmodule

bind chp_hdr_parser chp_hdr_parser_chk i_chp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .hdr_valid(hdr_valid),
    .trunc_err(trunc_err),
    .pay_start(pay_start),
    .src_code (src_code),
    .dst_code (dst_code),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .hdr_len  (hdr_len)
);

// File: tb/test_chp_hdr_parser.sv
// Scoreboard bench: the driver builds each frame from its fields, pushes
// the expected result into a queue, and a monitor compares at each result.
module test_chp_hdr_parser;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_last = 1'b0;
    logic [31:0]  in_data = '0;
    logic [15:0]  in_frm_len = '0;
    logic         hdr_valid, trunc_err, pay_start;
    logic [7:0]   traffic_class, next_hdr;
    logic [3:0]   hop_limit, src_code, dst_code;
    logic [19:0]  flow_label;
    logic [127:0] src_addr, dst_addr;
    logic [5:0]   hdr_len;
    logic [15:0]  pay_len;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct packed {
        logic         trunc;
        logic [7:0]   tc;
        logic [3:0]   hl;
        logic [19:0]  fl;
        logic [7:0]   nh;
        logic [3:0]   sal;
        logic [3:0]   dal;
        logic [127:0] src;
        logic [127:0] dst;
        logic [5:0]   hlen;
        logic [15:0]  plen;
        logic         has_pay;
        logic [31:0]  pay0;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    chp_hdr_parser i_chp_hdr_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_frm_len(in_frm_len),
        .hdr_valid(hdr_valid), .trunc_err(trunc_err), .pay_start(pay_start),
        .traffic_class(traffic_class), .hop_limit(hop_limit), .flow_label(flow_label),
        .next_hdr(next_hdr), .src_code(src_code), .dst_code(dst_code),
        .src_addr(src_addr), .dst_addr(dst_addr), .hdr_len(hdr_len), .pay_len(pay_len)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Build and send one frame; cut > 0 sends only that many words (truncation).
    task automatic send_frame(input logic [3:0] sal, input logic [3:0] dal,
                              input int npay, input int cut, input logic [7:0] seed);
        logic [7:0] hb [0:47];
        exp_t e;
        int sab, dab, hl, nhw, nw;
        sab = (sal == 0) ? 16 : int'(sal);
        dab = (dal == 0) ? 16 : int'(dal);
        hl  = ((6 + sab + dab + 3) / 4) * 4;
        nhw = hl / 4;
        for (int i = 0; i < 48; i++) hb[i] = 8'hA5;   // padding pattern (R7)
        e = '0;
        e.tc  = seed ^ 8'h3C;
        e.hl  = seed[3:0] ^ 4'h9;
        e.fl  = {seed[3:0], 8'h5A, seed};
        e.nh  = seed + 8'h11;
        e.sal = sal;
        e.dal = dal;
        hb[0] = e.tc;
        hb[1] = {e.hl, e.fl[19:16]};
        hb[2] = e.fl[15:8];
        hb[3] = e.fl[7:0];
        hb[4] = e.nh;
        hb[5] = {sal, dal};
        for (int i = 0; i < sab; i++) begin
            hb[6+i] = seed + 8'(i * 7) + 8'h01;
            e.src = {e.src[119:0], hb[6+i]};
        end
        for (int i = 0; i < dab; i++) begin
            hb[6+sab+i] = seed + 8'(i * 13) + 8'h80;
            e.dst = {e.dst[119:0], hb[6+sab+i]};
        end
        e.hlen    = 6'(hl);
        e.plen    = 16'(hl + npay * 4 - 1) - 16'(hl);
        e.plen    = 16'(npay * 4);
        e.has_pay = (npay > 0);
        e.pay0    = {seed, 8'hC0, 8'h00, 8'h5E};
        nw = nhw + npay;
        if (cut > 0) begin
            nw = cut;
            e.trunc = 1'b1;
        end
        exp_q.push_back(e);
        for (int w = 0; w < nw; w++) begin
            @(posedge clk); #1;
            in_valid   = 1'b1;
            in_last    = (w == nw - 1);
            in_frm_len = 16'(hl + npay * 4);
            if (w < nhw) in_data = {hb[4*w], hb[4*w+1], hb[4*w+2], hb[4*w+3]};
            else         in_data = {seed, 8'hC0, 8'(w - nhw), 8'h5E};
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
    endtask

    // Monitor: compare each result or truncation pulse against the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (pay_start && !hdr_valid) chk("R9 stray pay_start", 1, 0);
            if (hdr_valid || trunc_err) begin
                if (exp_q.size() == 0) chk("R8 unexpected pulse", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    if (e.trunc) begin
                        chk("R10 trunc_err", trunc_err, 1);
                        chk("R10 no hdr_valid", hdr_valid, 0);
                    end else begin
                        chk("R10 no trunc on full header", trunc_err, 0);
                        chk("R1 traffic class", traffic_class, e.tc);
                        chk("R1 hop limit", hop_limit, e.hl);
                        chk("R1 flow label", flow_label, e.fl);
                        chk("R2 next header", next_hdr, e.nh);
                        chk("R2 src code", src_code, e.sal);
                        chk("R2 dst code", dst_code, e.dal);
                        chk("R3 R6 R7 src addr", src_addr, e.src);
                        chk("R3 R6 R7 dst addr", dst_addr, e.dst);
                        chk("R4 hdr_len", hdr_len, e.hlen);
                        chk("R5 pay_len", pay_len, e.plen);
                        chk("R9 pay_start", pay_start, e.has_pay);
                        if (e.has_pay) chk("R9 first payload word", in_data, e.pay0);
                    end
                end
            end
        end
    end

    // R8: result never on two consecutive cycles.
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_v && hdr_valid) chk("R8 double pulse", 1, 0);
        prev_v <= hdr_valid;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk("watchdog", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 hdr_valid at reset", hdr_valid, 0);
        chk("R11 trunc_err at reset", trunc_err, 0);
        chk("R11 pay_start at reset", pay_start, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R4 reference length pairs
        send_frame(4'd1, 4'd1, 3, 0, 8'h10);
        send_frame(4'd2, 4'd2, 2, 0, 8'h21);
        send_frame(4'd3, 4'd3, 1, 0, 8'h32);
        send_frame(4'd4, 4'd4, 4, 0, 8'h43);
        send_frame(4'd4, 4'd0, 2, 0, 8'h54);
        send_frame(4'd0, 4'd0, 1, 0, 8'h65);
        // uneven codes, padding in play (R6, R7)
        send_frame(4'd15, 4'd1, 2, 0, 8'h76);
        send_frame(4'd5, 4'd7, 1, 0, 8'h87);
        send_frame(4'd1, 4'd0, 3, 0, 8'h98);
        send_frame(4'd0, 4'd9, 2, 0, 8'hA9);
        // header ends with the frame: no payload marker (R9)
        send_frame(4'd2, 4'd3, 0, 0, 8'hBA);
        send_frame(4'd1, 4'd1, 0, 0, 8'hCB);
        // truncation (R10)
        send_frame(4'd1, 4'd1, 0, 1, 8'hDC);
        send_frame(4'd0, 4'd0, 2, 5, 8'hED);
        send_frame(4'd3, 4'd4, 0, 2, 8'hFE);
        // frame after truncation parses normally
        send_frame(4'd6, 4'd2, 1, 0, 8'h0F);
        for (int k = 0; k < 6; k++)
            send_frame(4'(k * 3 + 1), 4'(k * 5 + 2), k % 3, 0, 8'(k * 37 + 5));
        repeat (4) @(posedge clk);
        chk("R8 all expected results seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule